// File: doc/BRIEF.md
# Task Switch Request Validator

This block screens every task-control operation (call another process, return to the caller, switch to another process, and switch while leaving an exception or interrupt handler) before the operation is allowed to take effect. For each request strobe it reports, one clock later, one of three outcomes: proceed, skip the instruction with the zero flag set, or trap with an exception cause code. Its inputs are the requested operation, the caller's role, whether a handler is running, and the fields of the target descriptor that the surrounding logic has already fetched: valid bit, stored tag and active flag. It also receives the tag carried by the instruction and a marker for the end of each instruction queue.

Two kinds of rule apply. A caller with the wrong role, or a request made outside a handler when one is required, traps as an invalid operation. A second accepted switch inside one instruction queue traps as an illegal instruction. A target that is invalid, whose tag does not match, or that is already running where that matters makes the instruction skip quietly with the zero flag set. Accepted switches are not started at once: the block raises a one-cycle launch pulse only after the queue that held them has ended, so that the instructions already queued finish and write their results first.

Top module: `task_switch_gate`

## Requirements
- R1: Operation encoding on `req_op`: 2'b00 call, 2'b01 return, 2'b10 switch, 2'b11 switch-and-exit-handler. The outcome on `out_code` is 2'b00 proceed, 2'b01 skip with zero flag set, 2'b10 trap; `out_valid` pulses for exactly the one cycle after each `req_valid` cycle, and `out_code`/`out_cause` are registered in the same edge.
- R2: A call or switch requested while `caller_is_callee` is 1 traps with cause 3'd2 (invalid operation).
- R3: A return requested while `caller_is_callee` is 0 traps with cause 3'd2.
- R4: A switch-and-exit-handler requested while `in_handler` is 0 traps with cause 3'd2.
- R5: Once `SWITCH_LIMIT` (default 1) requests have been accepted in the current queue, any further request that passes the role check traps with cause 3'd1 (illegal instruction); skipped and trapped requests are not counted.
- R6: For call, switch and switch-and-exit, a clear `tgt_valid` or a `tgt_tag` unequal to `insn_tag` gives the skip outcome; a return ignores these fields.
- R7: For switch and switch-and-exit, a set `tgt_active` gives the skip outcome; a call and a return ignore it.
- R8: Check priority is role (trap 2), then per-queue limit (trap 1), then valid and tag (skip), then active (skip).
- R9: `out_cause` is 3'd0 whenever `out_code` is not the trap code; trap causes use 0 division by zero, 1 illegal instruction, 2 invalid operation, 3 access violation, 4 double exception, 5 page fault, and this block only raises 1 and 2.
- R10: `queue_end` clears the per-queue count; a request in the same cycle still belongs to the ending queue. `launch` pulses for one cycle, one cycle after a `queue_end`, if and only if that queue accepted at least one request.
- R11: After reset `out_valid`, `launch`, `out_code` and `out_cause` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per operation |
| req_op | input | 2 | Operation kind |
| caller_is_callee | input | 1 | 1 when the requester is a callee, 0 for the original process |
| in_handler | input | 1 | 1 while an exception or interrupt handler runs |
| tgt_valid | input | 1 | Valid bit of the target descriptor |
| tgt_tag | input | TAG_W | Tag stored in the target descriptor |
| tgt_active | input | 1 | Target process is currently running |
| insn_tag | input | TAG_W | Tag carried by the instruction |
| queue_end | input | 1 | Last cycle of the current instruction queue |
| out_valid | output | 1 | Outcome strobe |
| out_code | output | 2 | Outcome code |
| out_cause | output | 3 | Exception cause when trapping |
| launch | output | 1 | Start the accepted switch now that the queue has drained |

## Verification
Each operation is issued from both caller roles and both handler states, separating the role trap from the quiet skip. Target fields are varied one at a time (valid clear, tag differing, active set) on operations that must honour them and on those that must ignore them, showing which checks apply to which operation. Requests are stacked inside one queue, with and without an intervening queue end and with skipped requests between them, to tell the limit trap apart from the skip and to time the launch pulse. Combined faults show the priority between the two traps and between a trap and a skip.

// File: rtl/tsg_pkg.sv
// Shared encodings for the task switch request validator.
package tsg_pkg;

    typedef enum logic [1:0] {
        OP_CALL   = 2'b00,
        OP_RETURN = 2'b01,
        OP_SWITCH = 2'b10,
        OP_SWEXIT = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        RES_PROCEED = 2'b00,
        RES_SKIP    = 2'b01,
        RES_TRAP    = 2'b10
    } res_e;

    localparam logic [2:0] CAUSE_DIV_ZERO    = 3'd0;
    localparam logic [2:0] CAUSE_ILLEGAL     = 3'd1;
    localparam logic [2:0] CAUSE_INVALID_OP  = 3'd2;
    localparam logic [2:0] CAUSE_ACCESS      = 3'd3;
    localparam logic [2:0] CAUSE_DOUBLE      = 3'd4;
    localparam logic [2:0] CAUSE_PAGE_FAULT  = 3'd5;

endpackage

// File: rtl/tsg_role_check.sv
// Role check: decides whether the requester may issue this operation.
// Assumes the operation code is stable while the request is presented.
module tsg_role_check
    import tsg_pkg::*;
(
    input  logic [1:0] op,
    input  logic       caller_is_callee,
    input  logic       in_handler,
    output logic       role_ok
);

    // Per-operation permission rule.
    always_comb begin
        unique case (op_e'(op))
            OP_CALL,
            OP_SWITCH: role_ok = !caller_is_callee;
            OP_RETURN: role_ok = caller_is_callee;
            OP_SWEXIT: role_ok = in_handler;
            default:   role_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/tsg_target_check.sv
// Target check: flags a quiet skip when the fetched descriptor is unusable.
// Assumes descriptor fields are already read for the current request.
module tsg_target_check
    import tsg_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic [1:0]       op,
    input  logic             tgt_valid,
    input  logic [TAG_W-1:0] tgt_tag,
    input  logic             tgt_active,
    input  logic [TAG_W-1:0] insn_tag,
    output logic             bad_ident,
    output logic             busy_target
);

    logic uses_ident;
    logic needs_idle;
    logic ident_fail;

    // Which target checks apply to this operation.
    always_comb begin
        uses_ident = (op_e'(op) != OP_RETURN);
        needs_idle = (op_e'(op) == OP_SWITCH) || (op_e'(op) == OP_SWEXIT);
    end

    // Identity (valid and tag) failure, independent of operation.
    assign ident_fail = !tgt_valid || (tgt_tag != insn_tag);

    // Gate the raw failures by the operation's applicability.
    always_comb begin
        bad_ident   = uses_ident && ident_fail;
        busy_target = needs_idle && tgt_active;
    end

endmodule

// File: rtl/tsg_queue_tracker.sv
// Queue tracker: counts accepted switches in the current instruction queue
// and issues the deferred launch pulse once the queue has ended.
// Assumes queue_end marks the last cycle of a queue; a request in that
// cycle belongs to the queue that is ending.
module tsg_queue_tracker #(
    parameter int SWITCH_LIMIT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic queue_end,
    input  logic accept,
    output logic limit_hit,
    output logic launch
);

    localparam int CNT_W = (SWITCH_LIMIT < 1) ? 1 : $clog2(SWITCH_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(SWITCH_LIMIT);

    logic [CNT_W-1:0] accepted_cnt;

    // Limit reached for the current queue.
    assign limit_hit = (accepted_cnt >= LIMIT_V);

    // Accepted count: clears at queue end, otherwise counts acceptances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accepted_cnt <= '0;
        end else if (queue_end) begin
            accepted_cnt <= '0;
        end else if (accept && !limit_hit) begin
            accepted_cnt <= accepted_cnt + CNT_W'(1);
        end
    end

    // Launch pulse after a queue that accepted at least one switch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            launch <= 1'b0;
        end else begin
            launch <= queue_end && ((accepted_cnt != '0) || accept);
        end
    end

endmodule

// File: rtl/task_switch_gate.sv
// Task switch request validator top. Resolves role, per-queue limit and
// target checks in fixed priority and registers one outcome per request.
// Assumes req_valid is a single-cycle strobe with all fields valid with it.
module task_switch_gate
    import tsg_pkg::*;
#(
    parameter int TAG_W        = 8,
    parameter int SWITCH_LIMIT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic             caller_is_callee,
    input  logic             in_handler,
    input  logic             tgt_valid,
    input  logic [TAG_W-1:0] tgt_tag,
    input  logic             tgt_active,
    input  logic [TAG_W-1:0] insn_tag,
    input  logic             queue_end,
    output logic             out_valid,
    output logic [1:0]       out_code,
    output logic [2:0]       out_cause,
    output logic             launch
);

    logic       role_ok;
    logic       bad_ident;
    logic       busy_target;
    logic       limit_hit;
    logic       accept;
    res_e       res_next;
    logic [2:0] cause_next;

    tsg_role_check u_role (
        .op               (req_op),
        .caller_is_callee (caller_is_callee),
        .in_handler       (in_handler),
        .role_ok          (role_ok)
    );

    tsg_target_check #(.TAG_W(TAG_W)) u_tgt (
        .op          (req_op),
        .tgt_valid   (tgt_valid),
        .tgt_tag     (tgt_tag),
        .tgt_active  (tgt_active),
        .insn_tag    (insn_tag),
        .bad_ident   (bad_ident),
        .busy_target (busy_target)
    );

    tsg_queue_tracker #(.SWITCH_LIMIT(SWITCH_LIMIT)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .queue_end (queue_end),
        .accept    (accept),
        .limit_hit (limit_hit),
        .launch    (launch)
    );

    // Fixed-priority outcome: role trap, limit trap, identity skip, busy skip.
    always_comb begin
        res_next   = RES_PROCEED;
        cause_next = CAUSE_DIV_ZERO;
        if (!role_ok) begin
            res_next   = RES_TRAP;
            cause_next = CAUSE_INVALID_OP;
        end else if (limit_hit) begin
            res_next   = RES_TRAP;
            cause_next = CAUSE_ILLEGAL;
        end else if (bad_ident || busy_target) begin
            res_next   = RES_SKIP;
        end
    end

    // Only a proceeding request counts toward the queue limit.
    assign accept = req_valid && (res_next == RES_PROCEED);

    // Outcome register: loads on each request, strobe follows the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_code  <= RES_PROCEED;
            out_cause <= CAUSE_DIV_ZERO;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_code  <= res_next;
                out_cause <= cause_next;
            end
        end
    end

endmodule

// File: rtl/tsg_checker.sv
// Checker for the task switch request validator, bound to every instance.
// Observes ports only; relates requests to the outcome one cycle later.
module tsg_checker #(
    parameter int TAG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       req_op,
    input logic             caller_is_callee,
    input logic             in_handler,
    input logic             tgt_valid,
    input logic [TAG_W-1:0] tgt_tag,
    input logic [TAG_W-1:0] insn_tag,
    input logic             queue_end,
    input logic             out_valid,
    input logic [1:0]       out_code,
    input logic [2:0]       out_cause,
    input logic             launch
);

    assert_strobe_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    assert_strobe_has_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(req_valid));

    assert_code_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_code != 2'b11));

    assert_call_switch_role_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_op[0] && caller_is_callee)
        |=> (out_code == 2'b10 && out_cause == 3'd2));

    assert_return_role_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b01 && !caller_is_callee)
        |=> (out_code == 2'b10 && out_cause == 3'd2));

    assert_exit_handler_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b11 && !in_handler)
        |=> (out_code == 2'b10 && out_cause == 3'd2));

    assert_bad_target_no_proceed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != 2'b01 && (!tgt_valid || tgt_tag != insn_tag))
        |=> (out_code != 2'b00));

    assert_cause_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_code != 2'b10) |-> (out_cause == 3'd0));

    assert_trap_cause_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_code == 2'b10) |-> (out_cause == 3'd1 || out_cause == 3'd2));

    assert_launch_after_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(launch) |-> $past(queue_end));

endmodule

bind task_switch_gate tsg_checker #(.TAG_W(TAG_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .req_op           (req_op),
    .caller_is_callee (caller_is_callee),
    .in_handler       (in_handler),
    .tgt_valid        (tgt_valid),
    .tgt_tag          (tgt_tag),
    .insn_tag         (insn_tag),
    .queue_end        (queue_end),
    .out_valid        (out_valid),
    .out_code         (out_code),
    .out_cause        (out_cause),
    .launch           (launch)
);

// File: tb/sim_task_switch_gate.sv
// Directed bench for task_switch_gate: one task per scenario.
module sim_task_switch_gate;

    localparam int TAG_W = 8;
    localparam logic [1:0] CALL = 2'b00, RET = 2'b01, SW = 2'b10, SWX = 2'b11;
    localparam logic [1:0] GO = 2'b00, SKIP = 2'b01, TRAP = 2'b10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [1:0]       req_op = 2'b00;
    logic             caller_is_callee = 1'b0;
    logic             in_handler = 1'b0;
    logic             tgt_valid = 1'b0;
    logic [TAG_W-1:0] tgt_tag = '0;
    logic             tgt_active = 1'b0;
    logic [TAG_W-1:0] insn_tag = '0;
    logic             queue_end = 1'b0;
    logic             out_valid;
    logic [1:0]       out_code;
    logic [2:0]       out_cause;
    logic             launch;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    task_switch_gate #(.TAG_W(TAG_W), .SWITCH_LIMIT(1)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .caller_is_callee(caller_is_callee), .in_handler(in_handler),
        .tgt_valid(tgt_valid), .tgt_tag(tgt_tag), .tgt_active(tgt_active),
        .insn_tag(insn_tag), .queue_end(queue_end), .out_valid(out_valid),
        .out_code(out_code), .out_cause(out_cause), .launch(launch)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d expected=%0d", req, got, exp);
        end
    endtask

    // Issue one request; outputs are sampled on the following falling edge.
    task automatic issue(input logic [1:0] op, input logic callee, input logic inh,
                         input logic tv, input logic [TAG_W-1:0] ttag,
                         input logic tact, input logic [TAG_W-1:0] itag,
                         input logic qend);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; caller_is_callee = callee;
        in_handler = inh; tgt_valid = tv; tgt_tag = ttag; tgt_active = tact;
        insn_tag = itag; queue_end = qend;
        @(negedge clk);
        req_valid = 1'b0; queue_end = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [1:0] code, input logic [2:0] cause);
        chk({req, " strobe"}, int'(out_valid), 1);
        chk({req, " code"}, int'(out_code), int'(code));
        chk({req, " cause"}, int'(out_cause), int'(cause));
    endtask

    // Standalone queue end; returns the launch value seen one cycle later.
    task automatic end_queue(output logic seen);
        @(negedge clk);
        queue_end = 1'b1;
        @(negedge clk);
        queue_end = 1'b0;
        seen = launch;
    endtask

    task automatic t_reset();
        chk("R11 out_valid", int'(out_valid), 0);
        chk("R11 out_code", int'(out_code), 0);
        chk("R11 out_cause", int'(out_cause), 0);
        chk("R11 launch", int'(launch), 0);
    endtask

    task automatic t_basic_and_launch();
        logic l;
        issue(CALL, 0, 0, 1, 8'h3C, 0, 8'h3C, 0);
        expect_out("R1 call proceeds", GO, 3'd0);
        chk("R10 no launch before end", int'(launch), 0);
        @(negedge clk);
        chk("R1 strobe one cycle", int'(out_valid), 0);
        end_queue(l);
        chk("R10 launch after end", int'(l), 1);
        @(negedge clk);
        chk("R10 launch single pulse", int'(launch), 0);
    endtask

    task automatic t_roles();
        logic l;
        issue(CALL, 1, 0, 1, 8'h11, 0, 8'h11, 0);
        expect_out("R2 call from callee", TRAP, 3'd2);
        issue(SW, 1, 1, 1, 8'h11, 0, 8'h11, 0);
        expect_out("R2 switch from callee", TRAP, 3'd2);
        issue(RET, 0, 0, 1, 8'h11, 0, 8'h11, 0);
        expect_out("R3 return from original", TRAP, 3'd2);
        issue(SWX, 0, 0, 1, 8'h11, 0, 8'h11, 0);
        expect_out("R4 exit outside handler", TRAP, 3'd2);
        end_queue(l);
        chk("R10 no launch after traps", int'(l), 0);
        issue(RET, 1, 0, 0, 8'h00, 1, 8'h55, 0);
        expect_out("R6 R7 return ignores target", GO, 3'd0);
        end_queue(l);
        issue(SWX, 0, 1, 1, 8'h22, 0, 8'h22, 0);
        expect_out("R4 exit inside handler", GO, 3'd0);
        end_queue(l);
    endtask

    task automatic t_target();
        logic l;
        issue(CALL, 0, 0, 1, 8'h40, 0, 8'h41, 0);
        expect_out("R6 tag mismatch", SKIP, 3'd0);
        issue(SW, 0, 0, 0, 8'h40, 0, 8'h40, 0);
        expect_out("R6 invalid target", SKIP, 3'd0);
        issue(SW, 0, 0, 1, 8'h40, 1, 8'h40, 0);
        expect_out("R7 switch to active", SKIP, 3'd0);
        issue(SWX, 0, 1, 1, 8'h40, 1, 8'h40, 0);
        expect_out("R7 exit to active", SKIP, 3'd0);
        end_queue(l);
        chk("R5 skips not counted", int'(l), 0);
        issue(CALL, 0, 0, 1, 8'h40, 1, 8'h40, 0);
        expect_out("R7 call ignores active", GO, 3'd0);
        end_queue(l);
    endtask

    task automatic t_queue_limit();
        logic l;
        issue(CALL, 0, 0, 1, 8'h01, 0, 8'h02, 0);
        expect_out("R5 skip first", SKIP, 3'd0);
        issue(SW, 0, 0, 1, 8'h07, 0, 8'h07, 0);
        expect_out("R5 first accept", GO, 3'd0);
        issue(CALL, 0, 0, 1, 8'h07, 0, 8'h07, 0);
        expect_out("R5 second switch", TRAP, 3'd1);
        issue(RET, 0, 0, 1, 8'h07, 0, 8'h07, 0);
        expect_out("R8 role before limit", TRAP, 3'd2);
        issue(SW, 0, 0, 0, 8'h07, 1, 8'h08, 1);
        expect_out("R8 limit before skip", TRAP, 3'd1);
        chk("R10 launch with end request", int'(launch), 1);
        issue(SW, 0, 0, 1, 8'h09, 0, 8'h09, 0);
        expect_out("R10 count cleared", GO, 3'd0);
        end_queue(l);
        chk("R10 launch second queue", int'(l), 1);
    endtask

    task automatic t_accept_on_end();
        logic l;
        issue(CALL, 0, 0, 1, 8'h5A, 0, 8'h5A, 1);
        expect_out("R10 accept on end cycle", GO, 3'd0);
        chk("R10 launch same queue", int'(launch), 1);
        issue(CALL, 0, 0, 1, 8'h5A, 0, 8'h5A, 0);
        expect_out("R10 next queue fresh", GO, 3'd0);
        end_queue(l);
        chk("R10 launch for fresh queue", int'(l), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_basic_and_launch();
        t_roles();
        t_target();
        t_queue_limit();
        t_accept_on_end();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule